// File: doc/BRIEF.md
# Modem Status Loopback Logic

This block holds the five-bit modem control value written by software and derives from it the eight-bit modem status value that software reads back. No external modem pins are sampled. When the loopback control bit is clear, the line inputs are modelled as fixed: carrier detect and data-set-ready read as asserted, while clear-to-send and ring read as clear. When loopback is set, the control outputs are mirrored onto the status inputs.

The lower nibble of the status value holds sticky change-detect flags. Each control write compares the old and new line states and raises the flags for lines that changed. The ring flag is the exception: it rises only when ring falls from 1 to 0. A status read returns the whole value and clears the flags on the following edge. The `deltaPend` output tells the interrupt logic that at least one flag is set.

Top module: `mdm_loop_stat`

## Requirements
- R1: After reset, `ctlReg` is 0, `statReg` is 0xA0 and `deltaPend` is 0.
- R2: A cycle with `ctlWrEn` high stores `ctlWrData[4:0]` into `ctlReg` on that edge. Bits 7:5 of the write data are discarded.
- R3: Loopback is `ctlReg[4]`. When it is 1, status bits 7:4 equal control bits {3,2,0,1}. Control bit 1 (RTS) appears as status bit 4 (CTS), bit 0 (DTR) as bit 5 (DSR), bit 2 (OUT1) as bit 6 (RI), and bit 3 (OUT2) as bit 7 (DCD).
- R4: When `ctlReg[4]` is 0, status bits 7:4 read 4'b1010: DCD and DSR are set, RI and CTS are clear.
- R5: A control write that changes CTS, DSR or DCD sets status bit 0, 1 or 3 respectively.
- R6: Status bit 2 (trailing-edge ring) is set only by a write that takes RI from 1 to 0. A 0-to-1 change of RI never sets it.
- R7: Without a status read, a set change flag stays set across any number of control writes.
- R8: A cycle with `statRdEn` high clears bits 3:0 on that edge. If a control write happens in the same cycle, the flags raised by that write remain set.
- R9: `deltaPend` is 1 exactly when any of status bits 3:0 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctlWrEn | input | 1 | Control register write strobe |
| ctlWrData | input | 8 | Control write data (bits 4:0 used) |
| statRdEn | input | 1 | Status read strobe (clears change flags) |
| ctlReg | output | 5 | Stored control value |
| statReg | output | 8 | Current status value |
| deltaPend | output | 1 | Any change flag set |

## Verification
Random control writes alternate between loopback and normal mode. This exercises both the mirroring and the fixed line states, as well as the change flags raised when the block enters or leaves loopback. Directed sequences drive RI up and then down to separate the trailing-edge ring flag from a plain change detector. A read issued in the same cycle as a write shows whether the clear is applied before or after the new flags are set. Reads mixed randomly with writes check that the flags stay set until a read and no longer.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int CTL_W  = 5;
  localparam int STAT_W = 8;
  localparam int NIB_W  = STAT_W / 2;

  // control bit positions
  localparam int C_DTR  = 0;
  localparam int C_RTS  = 1;
  localparam int C_OUT1 = 2;
  localparam int C_OUT2 = 3;
  localparam int C_LOOP = 4;

  // line-state nibble positions (status bits 7:4)
  localparam int L_CTS = 0;
  localparam int L_DSR = 1;
  localparam int L_RI  = 2;
  localparam int L_DCD = 3;

  localparam logic [NIB_W-1:0] IDLE_LINES = 4'b1010;

  typedef struct packed {
    logic loadCtl;
    logic clrDelta;
  } mdmStrobeT;

  function automatic logic [NIB_W-1:0] lineState(input logic [CTL_W-1:0] ctl);
    logic [NIB_W-1:0] res;
    if (ctl[C_LOOP]) begin
      res[L_CTS] = ctl[C_RTS];
      res[L_DSR] = ctl[C_DTR];
      res[L_RI]  = ctl[C_OUT1];
      res[L_DCD] = ctl[C_OUT2];
    end else begin
      res = IDLE_LINES;
    end
    return res;
  endfunction
endpackage

// File: rtl/mdm_ctrl.sv
module mdm_ctrl
  import mdm_pkg::*;
(
  input  logic      wrEn,
  input  logic      rdEn,
  output mdmStrobeT strobe
);
  always_comb begin
    strobe.loadCtl  = wrEn;
    strobe.clrDelta = rdEn;
  end
endmodule

// File: rtl/mdm_dp.sv
module mdm_dp
  import mdm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  mdmStrobeT         strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [CTL_W-1:0]  ctlQ,
  output logic [STAT_W-1:0] statQ,
  output logic              anyDelta
);
  logic [NIB_W-1:0] hiQ, dltQ, newHi, chg, dltNext;

  assign newHi = lineState(wrData[CTL_W-1:0]);

  // level lines flag any change; ring flags only its falling edge
  genvar gi;
  generate
    for (gi = 0; gi < NIB_W; gi++) begin : g_chg
      if (gi == L_RI) begin : g_trail
        assign chg[gi] = hiQ[gi] & ~newHi[gi];
      end else begin : g_level
        assign chg[gi] = hiQ[gi] ^ newHi[gi];
      end
    end
  endgenerate

  always_comb begin
    dltNext = strobe.clrDelta ? '0 : dltQ;
    if (strobe.loadCtl) dltNext = dltNext | chg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlQ <= '0;
      hiQ  <= IDLE_LINES;
      dltQ <= '0;
    end else begin
      if (strobe.loadCtl) begin
        ctlQ <= wrData[CTL_W-1:0];
        hiQ  <= newHi;
      end
      dltQ <= dltNext;
    end
  end

  assign statQ    = {hiQ, dltQ};
  assign anyDelta = |dltQ;
endmodule

// File: rtl/mdm_loop_stat.sv
module mdm_loop_stat
  import mdm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlWrEn,
  input  logic [DATA_W-1:0] ctlWrData,
  input  logic              statRdEn,
  output logic [CTL_W-1:0]  ctlReg,
  output logic [STAT_W-1:0] statReg,
  output logic              deltaPend
);
  mdmStrobeT strobe;

  mdm_ctrl ctrl_i (
    .wrEn   (ctlWrEn),
    .rdEn   (statRdEn),
    .strobe (strobe)
  );

  mdm_dp #(.DATA_W(DATA_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (ctlWrData),
    .ctlQ     (ctlReg),
    .statQ    (statReg),
    .anyDelta (deltaPend)
  );
endmodule

// File: rtl/mdm_loop_stat_chk.sv
module mdm_loop_stat_chk (
  input logic       clk,
  input logic       rstN,
  input logic       ctlWrEn,
  input logic [7:0] ctlWrData,
  input logic       statRdEn,
  input logic [4:0] ctlReg,
  input logic [7:0] statReg,
  input logic       deltaPend
);
  AST_CTL_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    ctlWrEn |=> ctlReg == $past(ctlWrData[4:0])); // R2
  AST_LOOP_MIRROR: assert property (@(posedge clk) disable iff (!rstN)
    ctlReg[4] |-> statReg[7:4] == {ctlReg[3], ctlReg[2], ctlReg[0], ctlReg[1]}); // R3
  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rstN)
    !ctlReg[4] |-> statReg[7:4] == 4'b1010); // R4
  AST_RI_TRAIL: assert property (@(posedge clk) disable iff (!rstN)
    (!statReg[6] && !statReg[2]) |=> !statReg[2]); // R6
  AST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !statRdEn |=> (statReg[3:0] & $past(statReg[3:0])) == $past(statReg[3:0])); // R7
  AST_READ_CLR: assert property (@(posedge clk) disable iff (!rstN)
    (statRdEn && !ctlWrEn) |=> statReg[3:0] == 4'b0000); // R8
  AST_PEND: assert property (@(posedge clk) disable iff (!rstN)
    deltaPend == (statReg[3:0] != 4'b0000)); // R9
endmodule

bind mdm_loop_stat mdm_loop_stat_chk chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .ctlWrEn   (ctlWrEn),
  .ctlWrData (ctlWrData),
  .statRdEn  (statRdEn),
  .ctlReg    (ctlReg),
  .statReg   (statReg),
  .deltaPend (deltaPend)
);

// File: tb/mdm_loop_stat_tb_top.sv
module mdm_loop_stat_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ctlWrEn = 1'b0;
  logic [7:0] ctlWrData = '0;
  logic       statRdEn = 1'b0;
  logic [4:0] ctlReg;
  logic [7:0] statReg;
  logic       deltaPend;

  int errCnt = 0;
  int chkCnt = 0;
  logic [4:0] mCtl;
  logic [3:0] mHi, mDlt;

  always #2.5 clk = ~clk;

  mdm_loop_stat dut_i (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .statRdEn(statRdEn), .ctlReg(ctlReg), .statReg(statReg), .deltaPend(deltaPend)
  );

  function automatic logic [3:0] expLines(input logic [4:0] c);
    if (c[4]) return {c[3], c[2], c[0], c[1]};
    return 4'b1010;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    check(req, {27'd0, ctlReg}, {27'd0, mCtl});
    check(req, {24'd0, statReg}, {24'd0, mHi, mDlt});
    check("R9", {31'd0, deltaPend}, {31'd0, |mDlt});
  endtask

  // drive one cycle at the falling edge, update the model, sample at the next falling edge
  task automatic op(input logic wr, input logic [7:0] d, input logic rd);
    logic [3:0] nh, ch;
    ctlWrEn = wr; ctlWrData = d; statRdEn = rd;
    nh = expLines(d[4:0]);
    ch[0] = nh[0] ^ mHi[0];
    ch[1] = nh[1] ^ mHi[1];
    ch[2] = mHi[2] & ~nh[2];
    ch[3] = nh[3] ^ mHi[3];
    if (rd) mDlt = '0;
    if (wr) begin mDlt |= ch; mHi = nh; mCtl = d[4:0]; end
    @(negedge clk);
    ctlWrEn = 1'b0; statRdEn = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errCnt++; chkCnt++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    mCtl = '0; mHi = 4'b1010; mDlt = '0;
    check("R1", {24'd0, statReg}, 32'hA0);
    check("R1", {27'd0, ctlReg}, 32'h0);
    check("R1", {31'd0, deltaPend}, 32'h0);

    // R2: upper bits discarded, non-loop keeps idle lines (R4)
    op(1'b1, 8'hE3, 1'b0); checkAll("R2");
    check("R4", {28'd0, statReg[7:4]}, 32'hA);
    // R3: enter loopback with RTS only -> CTS set, DSR/DCD drop (R5)
    op(1'b1, 8'h12, 1'b0); checkAll("R3");
    check("R5", {28'd0, statReg[3:0]}, 32'hB);
    // R8: read clears
    op(1'b0, 8'h00, 1'b1); checkAll("R8");
    check("R8", {28'd0, statReg[3:0]}, 32'h0);
    // R6: RI rising does not set TERI
    op(1'b1, 8'h16, 1'b0); checkAll("R6");
    check("R6", {31'd0, statReg[2]}, 32'h0);
    // R6: RI falling sets TERI; same-cycle read keeps new flags (R8)
    op(1'b1, 8'h12, 1'b1); checkAll("R6");
    check("R8", {28'd0, statReg[3:0]}, 32'h4);
    // R7: flags persist across a non-changing write
    op(1'b1, 8'h12, 1'b0); checkAll("R7");
    check("R7", {31'd0, statReg[2]}, 32'h1);
    // R3: full mirror all ones
    op(1'b1, 8'h1F, 1'b1); checkAll("R3");
    check("R3", {28'd0, statReg[7:4]}, 32'hF);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      op(r[0] | r[1], r[15:8], r[2] & r[3]);
      checkAll((r[12]) ? "R3" : "R4");
      if (r[4] == 1'b0 && r[5]) op(1'b0, 8'h00, 1'b0);
    end
    checkAll("R7");

    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end
endmodule